// File: doc/BRIEF.md
# Exception Stack Frame Sequencer

This block moves a processor into an exception handler and back out again. On an entry request it forms the new status register (SR) and aligns the supervisor stack pointer. It then pushes a stack frame whose layout follows a 4-bit format code, one 16-bit or 32-bit store at a time. Last, it reads the handler address from the vector table. On a return request it pops the saved SR, PC and format word, and steps the stack pointer past any extra words that the format carries.

Two supervisor stacks exist, the master stack and the interrupt stack. The `cur_sp` input is the active one and `alt_sp` is the other. A hardware interrupt that arrives while the master bit (SR bit 12) is set causes a double push. A format-0 frame goes on the master stack and a format-1 "throwaway" frame goes on the interrupt stack. Return unwinds such a frame by swapping stacks and restarting the pop sequence. The core around the block supplies the SR, PC and stack values. It takes the updated values in the cycle where `done` pulses.

Top module: `exc_frame_seq`

## Requirements
- R1: On entry the result SR is the old SR with bit 13 (supervisor) set and bit 15 (trace) cleared. For a hardware interrupt, bits 10:8 take the pending level. The other bits are kept, except that bit 12 is cleared after a throwaway push (R6).
- R2: With `UNALIGNED_OK`=0, bit 0 of each stack pointer is cleared before the first push on that stack.
- R3: Frame words are written toward lower addresses, each at the stack pointer minus its size. The order is: extra longwords, then the 16-bit format word, then the 32-bit return PC (`cur_pc`), then the 16-bit SR. The SR stored in the first frame is the SR from before entry.
- R4: The format word holds the format code in bits 15:12, plus the vector number multiplied by four.
- R5: Extra longwords by format: format 4 pushes `cur_pc` and then the fault address; formats 2 and 3 push the fault address only; every other format pushes none.
- R6: A hardware interrupt with old SR bit 12 set pushes a format-0 frame on `cur_sp`, then a format-1 frame on the aligned `alt_sp`. The format-1 frame stores the new SR with bit 12 still set. On completion `new_sp` is the interrupt-stack frame bottom, `new_alt_sp` is the master-stack frame bottom, and SR bit 12 is cleared.
- R7: After pushing, one 32-bit read from `vbr` + 4×vector gives `new_pc`, and `new_sp` is the address of the last word pushed.
- R8: Return reads the SR (16-bit) at SP, the PC (32-bit) at SP+2 and the format word at SP+6. The final SP is SP+8 plus 0, 4, 8 or 52 bytes for format 0, 2 or 3, 4 and 7 respectively.
- R9: A popped format-1 word swaps the stacks: the interrupt-stack value after the pop goes to `new_alt_sp`, and popping restarts at the former `alt_sp`.
- R10: A popped format code of 5, 6 or 8 to 15 raises `fmt_err` with `done`. `new_sr`, `new_pc`, `new_sp` and `new_alt_sp` then equal the values present at acceptance.
- R11: An access holds `mem_req`, `mem_addr`, `mem_wdata`, `mem_we` and `mem_long` unchanged until a cycle with `mem_ready` high.
- R12: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse. Requests made while busy are ignored. If both requests arrive together, entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_req | input | 1 | Start exception entry (taken when idle) |
| ret_req | input | 1 | Start exception return (taken when idle) |
| req_vec | input | VW | Vector number |
| req_fmt | input | 4 | Frame format code for entry |
| req_fault | input | 32 | Fault address for formats 2, 3 and 4 |
| req_hw | input | 1 | Entry is a hardware interrupt |
| req_level | input | 3 | Pending interrupt level |
| cur_sr | input | 16 | Current status register |
| cur_pc | input | 32 | Current program counter |
| cur_sp | input | 32 | Active supervisor stack pointer |
| alt_sp | input | 32 | The other supervisor stack pointer |
| vbr | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit access, 0 = 16-bit access (low half of data) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: results valid |
| fmt_err | output | 1 | Unsupported format on return, valid with done |
| new_sr | output | 16 | Updated SR |
| new_pc | output | 32 | Updated PC |
| new_sp | output | 32 | Updated active stack pointer |
| new_alt_sp | output | 32 | Updated other stack pointer |

## Verification
The properties check the following on every cycle:
- the memory handshake stays stable while waiting;
- no access occurs outside `busy`, and `done` is a single pulse;
- every entry write falls on an even address;
- the vector read targets `vbr` + 4×vector;
- each completed entry leaves the supervisor bit set and the trace bit clear;
- a format error returns the original stack pointer.

Only the directed scenarios can show the frame contents:
- the exact byte layout and push order for formats 0, 2 and 4;
- the double frame built on two stacks for an interrupt in master mode;
- the unwinding of that frame on return;
- the 52-byte skip for format 7.

// File: rtl/exc_frame_seq.sv
module exc_frame_seq #(
  parameter bit UNALIGNED_OK = 1'b0,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_req,
  input  logic          ret_req,
  input  logic [VW-1:0] req_vec,
  input  logic [3:0]    req_fmt,
  input  logic [31:0]   req_fault,
  input  logic          req_hw,
  input  logic [2:0]    req_level,
  input  logic [15:0]   cur_sr,
  input  logic [31:0]   cur_pc,
  input  logic [31:0]   cur_sp,
  input  logic [31:0]   alt_sp,
  input  logic [31:0]   vbr,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_long,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          fmt_err,
  output logic [15:0]   new_sr,
  output logic [31:0]   new_pc,
  output logic [31:0]   new_sp,
  output logic [31:0]   new_alt_sp
);
  localparam int SUP_BIT = 13;
  localparam int TRC_BIT = 15;
  localparam int MST_BIT = 12;
  localparam int VOFS_W  = 12;

  typedef enum logic [2:0] {S_IDLE, S_PUSH, S_VEC, S_PSR, S_PPC, S_PFMT} st_t;

  st_t          st;
  logic [2:0]   ps;
  logic [3:0]   fmt_r;
  logic [VW-1:0] vec_r;
  logic [31:0]  fault_r, pc0, sp0, alt0, vbr_r;
  logic [15:0]  sr0, sr_r;
  logic [31:0]  pc_r, sp_r, alt_r;
  logic         tw_next, tw, done_r, err_r;
  logic [15:0]  entry_sr;
  logic [31:0]  step;
  logic [3:0]   pop_fmt;

  function automatic logic [31:0] align(input logic [31:0] v);
    return UNALIGNED_OK ? v : {v[31:1], 1'b0};
  endfunction

  function automatic logic [2:0] first_step(input logic [3:0] f);
    if (f == 4'd4) return 3'd0;
    if (f == 4'd2 || f == 4'd3) return 3'd1;
    return 3'd2;
  endfunction

  always_comb begin
    entry_sr = cur_sr;
    entry_sr[SUP_BIT] = 1'b1;
    entry_sr[TRC_BIT] = 1'b0;
    if (req_hw) entry_sr[10:8] = req_level;
  end

  assign busy     = (st != S_IDLE);
  assign mem_req  = busy;
  assign mem_we   = (st == S_PUSH);
  assign mem_long = (mem_we && ps != 3'd2 && ps != 3'd4) || st == S_VEC || st == S_PPC;
  assign step     = mem_long ? 32'd4 : 32'd2;
  assign pop_fmt  = mem_rdata[15:12];

  always_comb begin
    case (st)
      S_PUSH:  mem_addr = sp_r - step;
      S_VEC:   mem_addr = vbr_r + 32'({vec_r, 2'b00});
      default: mem_addr = sp_r;
    endcase
  end

  always_comb begin
    case (ps)
      3'd0:    mem_wdata = pc0;
      3'd1:    mem_wdata = fault_r;
      3'd2:    mem_wdata = {16'h0, fmt_r, VOFS_W'({vec_r, 2'b00})};
      3'd3:    mem_wdata = pc0;
      default: mem_wdata = {16'h0, tw ? sr_r : sr0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ps <= '0; fmt_r <= '0; vec_r <= '0;
      fault_r <= '0; pc0 <= '0; sp0 <= '0; alt0 <= '0; vbr_r <= '0;
      sr0 <= '0; sr_r <= '0; pc_r <= '0; sp_r <= '0; alt_r <= '0;
      tw_next <= 1'b0; tw <= 1'b0; done_r <= 1'b0; err_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      case (st)
        S_IDLE: begin
          sr0 <= cur_sr; pc0 <= cur_pc; sp0 <= cur_sp; alt0 <= alt_sp;
          vbr_r <= vbr; vec_r <= req_vec; fault_r <= req_fault;
          pc_r <= cur_pc; alt_r <= alt_sp; tw <= 1'b0;
          if (take_req) begin
            sr_r    <= entry_sr;
            sp_r    <= align(cur_sp);
            tw_next <= req_hw && cur_sr[MST_BIT];
            fmt_r   <= (req_hw && cur_sr[MST_BIT]) ? 4'd0 : req_fmt;
            ps      <= first_step((req_hw && cur_sr[MST_BIT]) ? 4'd0 : req_fmt);
            st      <= S_PUSH;
          end else if (ret_req) begin
            sr_r <= cur_sr;
            sp_r <= cur_sp;
            st   <= S_PSR;
          end
        end
        S_PUSH: if (mem_ready) begin
          sp_r <= mem_addr;
          if (ps == 3'd4) begin
            if (tw_next) begin
              tw_next <= 1'b0;
              tw      <= 1'b1;
              fmt_r   <= 4'd1;
              ps      <= 3'd2;
              sp_r    <= align(alt_r);
              alt_r   <= mem_addr;
            end else begin
              st <= S_VEC;
            end
          end else begin
            ps <= ps + 3'd1;
          end
        end
        S_VEC: if (mem_ready) begin
          pc_r <= mem_rdata;
          if (tw) sr_r[MST_BIT] <= 1'b0;
          done_r <= 1'b1;
          st <= S_IDLE;
        end
        S_PSR: if (mem_ready) begin
          sr_r <= mem_rdata[15:0];
          sp_r <= sp_r + 32'd2;
          st   <= S_PPC;
        end
        S_PPC: if (mem_ready) begin
          pc_r <= mem_rdata;
          sp_r <= sp_r + 32'd4;
          st   <= S_PFMT;
        end
        S_PFMT: if (mem_ready) begin
          case (pop_fmt)
            4'd1: begin
              sp_r  <= alt_r;
              alt_r <= sp_r + 32'd2;
              st    <= S_PSR;
            end
            4'd0:       begin sp_r <= sp_r + 32'd2;  done_r <= 1'b1; st <= S_IDLE; end
            4'd2, 4'd3: begin sp_r <= sp_r + 32'd6;  done_r <= 1'b1; st <= S_IDLE; end
            4'd4:       begin sp_r <= sp_r + 32'd10; done_r <= 1'b1; st <= S_IDLE; end
            4'd7:       begin sp_r <= sp_r + 32'd54; done_r <= 1'b1; st <= S_IDLE; end
            default: begin
              sr_r <= sr0; pc_r <= pc0; sp_r <= sp0; alt_r <= alt0;
              err_r <= 1'b1; done_r <= 1'b1; st <= S_IDLE;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done       = done_r;
  assign fmt_err    = err_r;
  assign new_sr     = sr_r;
  assign new_pc     = pc_r;
  assign new_sp     = sp_r;
  assign new_alt_sp = alt_r;
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
  parameter bit UNALIGNED_OK = 1'b0,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_req,
  input logic          ret_req,
  input logic [VW-1:0] req_vec,
  input logic [31:0]   vbr,
  input logic [31:0]   cur_sp,
  input logic          busy,
  input logic          done,
  input logic          fmt_err,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_long,
  input logic          mem_ready,
  input logic [31:0]   mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [15:0]   new_sr,
  input logic [31:0]   new_sp
);
  logic          ent;
  logic [VW-1:0] vec_l;
  logic [31:0]   vbr_l, sp_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent <= 1'b0; vec_l <= '0; vbr_l <= '0; sp_l <= '0;
    end else if (!busy && (take_req || ret_req)) begin
      ent <= take_req; vec_l <= req_vec; vbr_l <= vbr; sp_l <= cur_sp;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                              && $stable(mem_we) && $stable(mem_long));

  p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  p_sup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done && ent |-> new_sr[13] && !new_sr[15]);

  p_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ent && mem_req && !mem_we |-> mem_long && mem_addr == vbr_l + 32'({vec_l, 2'b00}));

  p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !UNALIGNED_OK && ent && mem_req && mem_we |-> !mem_addr[0]);

  p_err_sp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && fmt_err |-> new_sp == sp_l);
endmodule

bind exc_frame_seq exc_frame_seq_chk #(.UNALIGNED_OK(UNALIGNED_OK), .VW(VW)) u_chk (.*);

// File: tb/exc_frame_seq_tb.sv
module exc_frame_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic take_req = 0, ret_req = 0, req_hw = 0;
  logic [7:0] req_vec = 0;
  logic [3:0] req_fmt = 0;
  logic [31:0] req_fault = 0, cur_pc = 0, cur_sp = 0, alt_sp = 0, vbr = 32'h100;
  logic [2:0] req_level = 0;
  logic [15:0] cur_sr = 0;
  logic mem_req, mem_we, mem_long, mem_ready, busy, done, fmt_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, new_pc, new_sp, new_alt_sp;
  logic [15:0] new_sr;

  logic [7:0] mem [0:4095];
  logic pl_we = 0, pl_long = 0, slow = 0, tick = 0;
  logic [11:0] pl_addr = 0;
  logic [31:0] pl_data = 0;
  int total = 0, bad = 0, viol = 0, cyc = 0;
  logic w_prev = 0, we_prev = 0, lg_prev = 0;
  logic [31:0] a_prev = 0, d_prev = 0;
  logic [15:0] o_sr;
  logic [31:0] o_pc, o_sp, o_alt;
  logic o_err;

  always #5 clk = ~clk;

  exc_frame_seq u_dut (.*);

  always_comb begin
    logic [11:0] a;
    a = mem_addr[11:0];
    mem_rdata = mem_long ? {mem[a], mem[a+12'd1], mem[a+12'd2], mem[a+12'd3]}
                         : {16'h0, mem[a], mem[a+12'd1]};
  end

  always @(posedge clk) begin
    if (pl_we) begin
      if (pl_long) begin
        mem[pl_addr] <= pl_data[31:24]; mem[pl_addr+12'd1] <= pl_data[23:16];
        mem[pl_addr+12'd2] <= pl_data[15:8]; mem[pl_addr+12'd3] <= pl_data[7:0];
      end else begin
        mem[pl_addr] <= pl_data[15:8]; mem[pl_addr+12'd1] <= pl_data[7:0];
      end
    end
    if (mem_req && mem_ready && mem_we) begin
      if (mem_long) begin
        mem[mem_addr[11:0]] <= mem_wdata[31:24]; mem[mem_addr[11:0]+12'd1] <= mem_wdata[23:16];
        mem[mem_addr[11:0]+12'd2] <= mem_wdata[15:8]; mem[mem_addr[11:0]+12'd3] <= mem_wdata[7:0];
      end else begin
        mem[mem_addr[11:0]] <= mem_wdata[15:8]; mem[mem_addr[11:0]+12'd1] <= mem_wdata[7:0];
      end
    end
    tick <= ~tick;
    mem_ready <= rst_n && mem_req && !mem_ready && (!slow || tick);
    if (w_prev && (!mem_req || mem_addr != a_prev || mem_wdata != d_prev ||
                   mem_we != we_prev || mem_long != lg_prev)) viol <= viol + 1;
    w_prev <= mem_req && !mem_ready;
    a_prev <= mem_addr; d_prev <= mem_wdata; we_prev <= mem_we; lg_prev <= mem_long;
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem[a[11:0]], mem[a[11:0]+12'd1], mem[a[11:0]+12'd2], mem[a[11:0]+12'd3]};
  endfunction
  function automatic logic [15:0] rd16(input logic [31:0] a);
    return {mem[a[11:0]], mem[a[11:0]+12'd1]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [11:0] a, input logic [31:0] d, input logic lng);
    @(negedge clk); pl_we = 1; pl_addr = a; pl_data = d; pl_long = lng;
    @(negedge clk); pl_we = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin
      if (n == 2) begin take_req = 1; ret_req = 1; end
      else begin take_req = 0; ret_req = 0; end
      @(negedge clk); n++;
    end
    take_req = 0; ret_req = 0;
    if (n >= 3000) chk("R12 done never seen", 0, 1);
    o_sr = new_sr; o_pc = new_pc; o_sp = new_sp; o_alt = new_alt_sp; o_err = fmt_err;
    @(negedge clk);
    chk("R12 done is one cycle", {31'h0, done}, 0);
    chk("R12 busy low after done (late request ignored)", {31'h0, busy}, 0);
  endtask

  task automatic run_enter(input logic [7:0] vec, input logic [3:0] fmt, input logic [31:0] fault,
                           input logic hw, input logic [2:0] lvl, input logic [15:0] sr,
                           input logic [31:0] pc, input logic [31:0] sp, input logic [31:0] alt,
                           input logic both);
    @(negedge clk);
    req_vec = vec; req_fmt = fmt; req_fault = fault; req_hw = hw; req_level = lvl;
    cur_sr = sr; cur_pc = pc; cur_sp = sp; alt_sp = alt;
    take_req = 1; ret_req = both;
    @(negedge clk); take_req = 0; ret_req = 0;
    chk("R12 busy after accept", {31'h0, busy}, 1);
    wait_done();
  endtask

  task automatic run_ret(input logic [15:0] sr, input logic [31:0] pc,
                         input logic [31:0] sp, input logic [31:0] alt);
    @(negedge clk);
    cur_sr = sr; cur_pc = pc; cur_sp = sp; alt_sp = alt; ret_req = 1;
    @(negedge clk); ret_req = 0;
    chk("R12 busy after accept", {31'h0, busy}, 1);
    wait_done();
  endtask

  // Frame model from R3, R4, R5: returns the address of the last word.
  task automatic chk_frame(input logic [31:0] top, input logic [3:0] fmt, input logic [7:0] vec,
                           input logic [15:0] sr, input logic [31:0] pc, input logic [31:0] fault,
                           output logic [31:0] bottom);
    logic [31:0] a = top;
    if (fmt == 4) begin
      a -= 4; chk("R5 fmt4 extra pc", rd32(a), pc);
      a -= 4; chk("R5 fmt4 fault addr", rd32(a), fault);
    end else if (fmt == 2 || fmt == 3) begin
      a -= 4; chk("R5 fault addr", rd32(a), fault);
    end
    a -= 2; chk("R4 format word", {16'h0, rd16(a)}, {16'h0, fmt, 12'h0} + {22'h0, vec, 2'b00});
    a -= 4; chk("R3 return pc", rd32(a), pc);
    a -= 2; chk("R3 saved sr", {16'h0, rd16(a)}, {16'h0, sr});
    bottom = a;
  endtask

  task automatic t_reset();
    chk("R12 reset busy", {31'h0, busy}, 0);
    chk("R12 reset done", {31'h0, done}, 0);
    chk("R11 reset mem_req", {31'h0, mem_req}, 0);
  endtask

  task automatic t_fmt0_align();
    logic [31:0] b;
    run_enter(8'd5, 4'd0, 0, 0, 0, 16'h8304, 32'h12345678, 32'hA01, 32'hC00, 0);
    chk_frame(32'hA00, 4'd0, 8'd5, 16'h8304, 32'h12345678, 0, b);
    chk("R2 R7 new_sp aligned frame bottom", o_sp, b);
    chk("R1 sr S set T clear", {16'h0, o_sr}, 32'h2304);
    chk("R7 vector pc", o_pc, 32'h2000);
    run_ret(16'h2304, 32'h2000, 32'h9F8, 32'hC00);
    chk("R8 ret sr", {16'h0, o_sr}, 32'h8304);
    chk("R8 ret pc", o_pc, 32'h12345678);
    chk("R8 ret sp fmt0", o_sp, 32'hA00);
    chk("R10 no error", {31'h0, o_err}, 0);
  endtask

  task automatic t_fmt2_slow();
    logic [31:0] b;
    slow = 1;
    run_enter(8'd5, 4'd2, 32'hCAFEF00D, 0, 0, 16'h2700, 32'h4444, 32'hA00, 32'hC00, 0);
    chk_frame(32'hA00, 4'd2, 8'd5, 16'h2700, 32'h4444, 32'hCAFEF00D, b);
    chk("R7 fmt2 new_sp", o_sp, b);
    run_ret(16'h2700, 32'h2000, 32'h9F4, 32'hC00);
    chk("R8 fmt2 skip 4", o_sp, 32'hA00);
    chk("R8 fmt2 pc", o_pc, 32'h4444);
    chk("R11 handshake held while waiting", viol, 0);
    slow = 0;
  endtask

  task automatic t_fmt4();
    logic [31:0] b;
    run_enter(8'd11, 4'd4, 32'h00BADADD, 0, 0, 16'h0010, 32'h55AA55AA, 32'hA00, 32'hC00, 0);
    chk_frame(32'hA00, 4'd4, 8'd11, 16'h0010, 32'h55AA55AA, 32'h00BADADD, b);
    chk("R5 fmt4 new_sp", o_sp, b);
    chk("R1 fmt4 sr", {16'h0, o_sr}, 32'h2010);
    chk("R7 fmt4 pc", o_pc, 32'h2B00);
    run_ret(16'h2010, 32'h2B00, 32'h9F0, 32'hC00);
    chk("R8 fmt4 skip 8", o_sp, 32'hA00);
    chk("R8 fmt4 sr", {16'h0, o_sr}, 32'h0010);
  endtask

  task automatic t_hw_both();
    logic [31:0] b;
    run_enter(8'd29, 4'd0, 0, 1, 3'd5, 16'h2100, 32'h777, 32'hA00, 32'hC00, 1);
    chk_frame(32'hA00, 4'd0, 8'd29, 16'h2100, 32'h777, 0, b);
    chk("R12 entry wins, new_sp", o_sp, b);
    chk("R1 hw level into mask", {16'h0, o_sr}, 32'h2500);
    chk("R7 hw vector pc", o_pc, 32'h3D00);
  endtask

  task automatic t_throwaway();
    logic [31:0] b0, b1;
    run_enter(8'd30, 4'd2, 0, 1, 3'd6, 16'h3200, 32'h888, 32'hA00, 32'hC01, 0);
    chk_frame(32'hA00, 4'd0, 8'd30, 16'h3200, 32'h888, 0, b0);
    chk_frame(32'hC00, 4'd1, 8'd30, 16'h3600, 32'h888, 0, b1);
    chk("R6 new_sp on interrupt stack", o_sp, b1);
    chk("R6 alt sp is master bottom", o_alt, b0);
    chk("R6 R1 sr master cleared", {16'h0, o_sr}, 32'h2600);
    chk("R7 throwaway pc", o_pc, 32'h3E00);
    run_ret(16'h2600, 32'h3E00, 32'hBF8, 32'h9F8);
    chk("R9 unwound sr", {16'h0, o_sr}, 32'h3200);
    chk("R9 unwound pc", o_pc, 32'h888);
    chk("R9 master sp", o_sp, 32'hA00);
    chk("R9 interrupt sp", o_alt, 32'hC00);
  endtask

  task automatic t_fmt7();
    preload(12'h700, 32'h2004, 0);
    preload(12'h702, 32'hDEADBEEF, 1);
    preload(12'h706, 32'h7000, 0);
    run_ret(16'h2700, 32'h1, 32'h700, 32'hC00);
    chk("R8 fmt7 skip 52", o_sp, 32'h73C);
    chk("R8 fmt7 pc", o_pc, 32'hDEADBEEF);
    chk("R8 fmt7 sr", {16'h0, o_sr}, 32'h2004);
  endtask

  task automatic t_bad_fmt();
    preload(12'h780, 32'h2222, 0);
    preload(12'h782, 32'h11111111, 1);
    preload(12'h786, 32'h5008, 0);
    run_ret(16'h2700, 32'h9999, 32'h780, 32'hC00);
    chk("R10 fmt_err raised", {31'h0, o_err}, 1);
    chk("R10 sp unchanged", o_sp, 32'h780);
    chk("R10 sr unchanged", {16'h0, o_sr}, 32'h2700);
    chk("R10 pc unchanged", o_pc, 32'h9999);
    chk("R10 alt unchanged", o_alt, 32'hC00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    preload(12'h114, 32'h2000, 1);
    preload(12'h12C, 32'h2B00, 1);
    preload(12'h174, 32'h3D00, 1);
    preload(12'h178, 32'h3E00, 1);
    t_fmt0_align();
    t_fmt2_slow();
    t_fmt4();
    t_hw_both();
    t_throwaway();
    t_fmt7();
    t_bad_fmt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule